// File: doc/BRIEF.md
# Triggered Multi-Channel Sample Snapshot

This block takes a burst of samples from several ADC channels at once and keeps them for later inspection. Software writes a control word that holds a start bit and a trigger-source bit. A 0-to-1 change of the start bit arms the block. It then waits for a rising edge on the chosen trigger: either the sync pulse from the core board or the sync input on the front panel. Both trigger inputs are asynchronous. Each one passes through a synchronizer and an edge detector before it is used. On the trigger, every channel writes the same run of consecutive samples into its own buffer, and the block then reports done.

Software reads everything through one register window with simple read and write strobes. Offset 0 is the control and status word. Channel n (counted from 1) lives in page n of the window, one page per 0x1000 offsets. Each stored sample comes back zero-extended to the 16-bit data word.

Top module: `snap_capture`

## Requirements
- R1: After reset the block is idle, offset 0 reads 0x0000, and `host_rdata` is 0x0000.
- R2: A write to offset 0 stores bit 0 as the start bit and bit 1 as the trigger select (0 = core sync, 1 = panel sync). A read of offset 0 returns {done, capturing, armed, select, start} in bits 4 down to 0, with bits 15:5 zero. At most one of done, capturing and armed is set at any time.
- R3: Only a write that changes the stored start bit from 0 to 1 arms the block. Writing 1 while the start bit is already 1 leaves the state unchanged.
- R4: While armed, only a rising edge of the selected trigger starts a capture. Edges on the other trigger are ignored. A trigger that is already high when the block is armed does not count as an edge.
- R5: Each trigger input passes through two synchronizing flops and an edge detector. If the trigger is first sampled high at clock edge E, entry 0 holds the sample presented at edge E+3, and entry i holds the sample at edge E+3+i.
- R6: A capture writes exactly DEPTH consecutive samples into every channel buffer at the same clock edges. The block then goes to done and stops writing.
- R7: An arm request made during a capture is ignored. The capture runs to completion, and to arm again the start bit must go back to 0 and then to 1.
- R8: Arming from done clears done and enters armed. The buffers keep their previous contents until the next trigger.
- R9: A read of offset n·0x1000 + i, with 1 ≤ n ≤ NUM_CH and i < DEPTH, returns entry i of channel n zero-extended to 16 bits. Read data appears on `host_rdata` two clock edges after the read strobe and holds until the next read completes.
- R10: A read of any other offset inside the window returns 0x0000. This covers nonzero offsets in page 0 and offsets at or above DEPTH inside a channel page.
- R11: Writes to offsets other than 0 have no effect on the control word or on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and host clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_addr | input | ADDR_W | Offset inside the snapshot window |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Registered read data, two cycles after `host_rd` |
| sync_core | input | 1 | Asynchronous core-board sync pulse |
| sync_panel | input | 1 | Asynchronous front-panel sync input |
| adc_samples | input | NUM_CH*ADC_W | Channel samples, channel 1 in the low bits |

## Verification
The bench compares the read port on every clock against a behavioural reference model. It goes after the cases most likely to be miswired. A trigger that is already high when the block is armed must not start a capture; a design that treats a level as an edge would fire at once. The first and last entries show an off-by-one in the synchronizer latency or in the sample count as shifted or missing data. Re-arming while a capture runs, or writing 1 over a start bit that is already 1, must be ignored; a design that reacts would restart or corrupt the buffers. Reads of unmapped offsets and writes to them check that the address decode does not alias onto channel data or onto the control word.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DONE    = 2'd3
  } snap_state_e;

  localparam int STAT_W = 5;

  typedef struct packed {
    logic done;
    logic capturing;
    logic armed;
    logic trig_sel;
    logic start;
  } snap_status_t;

endpackage

// File: rtl/snap_sync_edge.sv
module snap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

  // R5: the detected edge is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_start,
  input  logic          cfg_sel,
  input  logic          core_rise,
  input  logic          panel_rise,
  output logic          cap_we,
  output logic [AW-1:0] cap_addr,
  output snap_status_t  stat
);

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  snap_state_e   state_q, state_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          start_q, sel_q;
  logic          arm_req, trig_hit;

  assign arm_req  = cfg_wr & cfg_start & ~start_q;
  assign trig_hit = sel_q ? panel_rise : core_rise;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (arm_req) state_d = ST_ARMED;
      ST_ARMED: begin
        if (!arm_req && trig_hit) begin
          state_d = ST_CAPTURE;
          cnt_d   = '0;
        end
      end
      ST_CAPTURE: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_DONE;
      end
      ST_DONE: if (arm_req) state_d = ST_ARMED;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (cfg_wr) begin
        start_q <= cfg_start;
        sel_q   <= cfg_sel;
      end
    end
  end

  assign cap_we   = (state_q == ST_CAPTURE);
  assign cap_addr = cnt_q;

  always_comb begin
    stat.done      = (state_q == ST_DONE);
    stat.capturing = (state_q == ST_CAPTURE);
    stat.armed     = (state_q == ST_ARMED);
    stat.trig_sel  = sel_q;
    stat.start     = start_q;
  end

  a_r2_status_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stat.done, stat.capturing, stat.armed}));

  a_r6_burst_ends: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAPTURE && cnt_q == LAST) |=> (state_q == ST_DONE));

  a_r7_capture_runs_on: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAPTURE && cnt_q != LAST) |=>
      (state_q == ST_CAPTURE && cnt_q == $past(cnt_q) + 1'b1));

  a_r3_level_no_arm: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && start_q) |=> (state_q == ST_DONE));

  a_r4_wait_for_edge: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARMED && !core_rise && !panel_rise) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/snap_chan_buf.sv
module snap_chan_buf #(
  parameter int AW = 8,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/snap_capture.sv
module snap_capture
  import snap_pkg::*;
#(
  parameter int NUM_CH     = 7,
  parameter int ADC_W      = 14,
  parameter int DW         = 16,
  parameter int DEPTH_LOG2 = 8,
  parameter int WIN_LOG2   = 12,
  parameter int ADDR_W     = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DW-1:0]           host_wdata,
  output logic [DW-1:0]           host_rdata,
  input  logic                    sync_core,
  input  logic                    sync_panel,
  input  logic [NUM_CH*ADC_W-1:0] adc_samples
);

  localparam int PAGE_W = ADDR_W - WIN_LOG2;

  logic [PAGE_W-1:0]     page;
  logic [WIN_LOG2-1:0]   off;
  logic                  ctrl_hit, buf_hit;
  logic                  core_rise, panel_rise;
  logic                  cap_we;
  logic [DEPTH_LOG2-1:0] cap_addr;
  snap_status_t          stat;
  logic [ADC_W-1:0]      dout [NUM_CH];
  logic [ADC_W-1:0]      pick;

  logic                  rd_q, ctrl_hit_q, buf_hit_q;
  logic [PAGE_W-1:0]     page_q;
  snap_status_t          stat_q;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^host_wdata[DW-1:2];

  assign page     = host_addr[ADDR_W-1:WIN_LOG2];
  assign off      = host_addr[WIN_LOG2-1:0];
  assign ctrl_hit = (page == '0) && (off == '0);
  assign buf_hit  = (page != '0) && (page <= PAGE_W'(NUM_CH)) && ((off >> DEPTH_LOG2) == '0);

  snap_sync_edge #(.STAGES(2)) u_core_sync (
    .clk(clk), .rst(rst), .async_in(sync_core), .rise(core_rise)
  );

  snap_sync_edge #(.STAGES(2)) u_panel_sync (
    .clk(clk), .rst(rst), .async_in(sync_panel), .rise(panel_rise)
  );

  snap_ctrl #(.AW(DEPTH_LOG2)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (host_wr && ctrl_hit),
    .cfg_start (host_wdata[0]),
    .cfg_sel   (host_wdata[1]),
    .core_rise (core_rise),
    .panel_rise(panel_rise),
    .cap_we    (cap_we),
    .cap_addr  (cap_addr),
    .stat      (stat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    snap_chan_buf #(.AW(DEPTH_LOG2), .DW(ADC_W)) u_buf (
      .clk  (clk),
      .we   (cap_we),
      .waddr(cap_addr),
      .wdata(adc_samples[c*ADC_W +: ADC_W]),
      .re   (host_rd),
      .raddr(host_addr[DEPTH_LOG2-1:0]),
      .rdata(dout[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= 1'b0;
      ctrl_hit_q <= 1'b0;
      buf_hit_q  <= 1'b0;
      page_q     <= '0;
      stat_q     <= '0;
    end else begin
      rd_q <= host_rd;
      if (host_rd) begin
        ctrl_hit_q <= ctrl_hit;
        buf_hit_q  <= buf_hit;
        page_q     <= page;
        stat_q     <= stat;
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (page_q == PAGE_W'(c + 1)) pick = dout[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (rd_q) begin
      if (ctrl_hit_q)     host_rdata <= DW'(stat_q);
      else if (buf_hit_q) host_rdata <= DW'(pick);
      else                host_rdata <= '0;
    end
  end

  a_r9_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_q |=> $stable(host_rdata));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !ctrl_hit_q && !buf_hit_q) |=> (host_rdata == '0));

  a_r9_zero_extend: assert property (@(posedge clk) disable iff (rst)
    (rd_q && buf_hit_q) |=> (host_rdata[DW-1:ADC_W] == '0));

endmodule

// File: tb/sim_snap_capture.sv
module sim_snap_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 7;
  localparam int ADC_W      = 14;
  localparam int DW         = 16;
  localparam int DEPTH_LOG2 = 8;
  localparam int WIN_LOG2   = 12;
  localparam int ADDR_W     = 15;
  localparam int DEPTH      = 1 << DEPTH_LOG2;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    host_wr = 1'b0, host_rd = 1'b0;
  logic [ADDR_W-1:0]       host_addr = '0;
  logic [DW-1:0]           host_wdata = '0;
  logic [DW-1:0]           host_rdata;
  logic                    sync_core = 1'b0, sync_panel = 1'b0;
  logic [NUM_CH*ADC_W-1:0] adc_samples = '0;

  int checks = 0, failures = 0, cyc = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_capture #(
    .NUM_CH(NUM_CH), .ADC_W(ADC_W), .DW(DW), .DEPTH_LOG2(DEPTH_LOG2),
    .WIN_LOG2(WIN_LOG2), .ADDR_W(ADDR_W)
  ) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sync_core(sync_core), .sync_panel(sync_panel), .adc_samples(adc_samples)
  );

  // ADC stimulus: a distinct ramp per channel
  always @(negedge clk) begin
    for (int c = 0; c < NUM_CH; c++)
      adc_samples[c*ADC_W +: ADC_W] <= ADC_W'(cyc * 37 + c * 1103 + 5);
  end

  // Reference model
  int m_cs[3], m_ps[3];
  int m_state, m_cnt, m_start, m_sel, m_p1, m_rdv, m_exp;
  int m_mem[NUM_CH][DEPTH];
  bit m_live = 0;
  int t_trig, t_look, t_arm, t_page, t_off;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int k = 0; k < 3; k++) begin m_cs[k] = 0; m_ps[k] = 0; end
      m_state = 0; m_cnt = 0; m_start = 0; m_sel = 0;
      m_p1 = 0; m_rdv = 0; m_exp = 0; m_live = 1;
    end else begin
      t_trig = m_sel ? int'(m_ps[1] == 1 && m_ps[2] == 0) : int'(m_cs[1] == 1 && m_cs[2] == 0);
      t_page = int'(host_addr) / (1 << WIN_LOG2);
      t_off  = int'(host_addr) % (1 << WIN_LOG2);
      t_look = 0;
      if (t_page == 0 && t_off == 0)
        t_look = (int'(m_state == 3) << 4) | (int'(m_state == 2) << 3) |
                 (int'(m_state == 1) << 2) | (m_sel << 1) | m_start;
      else if (t_page >= 1 && t_page <= NUM_CH && t_off < DEPTH)
        t_look = m_mem[t_page-1][t_off];
      if (m_rdv != 0) m_exp = m_p1;
      m_rdv = int'(host_rd);
      if (host_rd) m_p1 = t_look;
      t_arm = int'(host_wr && host_addr == 0 && host_wdata[0] && m_start == 0);
      case (m_state)
        0: if (t_arm != 0) m_state = 1;
        1: if (t_arm == 0 && t_trig != 0) begin m_state = 2; m_cnt = 0; end
        2: begin
          for (int c = 0; c < NUM_CH; c++)
            m_mem[c][m_cnt] = int'(adc_samples[c*ADC_W +: ADC_W]);
          if (m_cnt == DEPTH - 1) m_state = 3;
          m_cnt++;
        end
        default: if (t_arm != 0) m_state = 1;
      endcase
      if (host_wr && host_addr == 0) begin
        m_start = int'(host_wdata[0]);
        m_sel   = int'(host_wdata[1]);
      end
      m_cs[2] = m_cs[1]; m_cs[1] = m_cs[0]; m_cs[0] = int'(sync_core);
      m_ps[2] = m_ps[1]; m_ps[1] = m_ps[0]; m_ps[0] = int'(sync_panel);
    end
  end

  // Every-cycle comparison of the read port
  always @(negedge clk) begin
    if (m_live && !rst) begin
      checks++;
      if (host_rdata !== DW'(m_exp)) begin
        failures++;
        $display("FAIL %s cycle %0d: rdata actual=%h expected=%h", phase, cyc, host_rdata, DW'(m_exp));
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic host_write(input int addr, input int data);
    @(negedge clk);
    host_wr = 1'b1; host_addr = ADDR_W'(addr); host_wdata = DW'(data);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input int addr, output int data);
    @(negedge clk);
    host_rd = 1'b1; host_addr = ADDR_W'(addr);
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    data = int'(host_rdata);
  endtask

  task automatic pulse(input bit panel);
    @(negedge clk);
    if (panel) sync_panel = 1'b1; else sync_core = 1'b1;
    repeat (3) @(negedge clk);
    if (panel) sync_panel = 1'b0; else sync_core = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    chk("R1 rdata after reset", int'(host_rdata), 0);
    host_read(0, v);
    chk("R1 control after reset", v, 0);

    phase = "R2";
    host_write(0, 1);
    host_read(0, v);
    chk("R2/R3 armed on start edge", v, 'h05);

    phase = "R4";
    pulse(1);
    repeat (6) @(negedge clk);
    host_read(0, v);
    chk("R4 other trigger ignored", v, 'h05);

    phase = "R6";
    pulse(0);
    repeat (DEPTH + 10) @(negedge clk);
    host_read(0, v);
    chk("R6 done after full burst", v, 'h11);

    phase = "R9";
    for (int i = 0; i < DEPTH; i++) host_read((1 << WIN_LOG2) + i, v);
    for (int i = 0; i < DEPTH; i++) host_read((NUM_CH << WIN_LOG2) + i, v);
    phase = "R5";
    for (int c = 1; c <= NUM_CH; c++) begin
      host_read((c << WIN_LOG2), v);
      host_read((c << WIN_LOG2) + DEPTH - 1, v);
    end

    phase = "R10";
    host_read(4, v);
    chk("R10 page 0 offset 4", v, 0);
    host_read((2 << WIN_LOG2) + DEPTH, v);
    chk("R10 beyond depth", v, 0);

    phase = "R3";
    host_write(0, 1);
    host_read(0, v);
    chk("R3 start held at 1 does not arm", v, 'h11);

    phase = "R11";
    host_write((1 << WIN_LOG2) + 5, 3);
    host_write(7, 3);
    host_read(0, v);
    chk("R11 write elsewhere ignored", v, 'h11);

    phase = "R8";
    host_write(0, 2);
    @(negedge clk); sync_panel = 1'b1;
    repeat (5) @(negedge clk);
    host_write(0, 3);
    host_read(0, v);
    chk("R8 re-arm clears done", v, 'h07);
    repeat (10) @(negedge clk);
    host_read(0, v);
    chk("R4 high level is not an edge", v, 'h07);
    host_read((3 << WIN_LOG2) + 9, v);

    phase = "R7";
    @(negedge clk); sync_panel = 1'b0;
    repeat (4) @(negedge clk);
    sync_panel = 1'b1;
    repeat (12) @(negedge clk);
    host_write(0, 2);
    host_write(0, 3);
    host_read(0, v);
    chk("R7 arm ignored while capturing", v, 'h0B);
    repeat (DEPTH + 10) @(negedge clk);
    host_read(0, v);
    chk("R7 capture completes to done", v, 'h13);
    host_write(0, 3);
    host_read(0, v);
    chk("R7 start still 1 needs 0 then 1", v, 'h13);
    sync_panel = 1'b0;

    phase = "R9";
    for (int i = 0; i < DEPTH; i++) host_read((4 << WIN_LOG2) + i, v);
    repeat (3) @(negedge clk);
    chk("R9 rdata held after reads", int'(host_rdata), m_exp);

    finish_run();
  end

endmodule